// File: doc/BRIEF.md
# In-Order Commit Checker

This block sits behind an out-of-order primary core and receives each finished instruction, oldest first, as the core retires it. Every packet carries the opcode, two source register indices, a destination index, the two operand values the core consumed, the result it produced and the instruction's program counter. The checker keeps its own copy of the architected register file. It reads the sources from that copy and compares them with the reported operands. It also recomputes the result on a private ALU and compares that with the reported result.

Only when both comparisons agree is the destination written and the commit shown on the commit port. On any disagreement the architected copy is trusted and left untouched. The checker then pulses a one-cycle flush, publishes the program counter to restart from, and discards every younger instruction still in its pipeline. A programmable idle timeout catches a primary core that has stopped retiring, for example one that is deadlocked. The pipeline has three steps: an input register, a read/recompute stage, and a compare/write stage. It never stalls, because a bypass forwards a result being written to a dependent instruction directly behind it.

Top module: `commit_checker`

## Requirements
- R1: After reset, in_ready_o is 1, flush_o is 0, commit_valid_o is 0, restart_pc_o and cause_o are 0, and every architected register reads as 0.
- R2: If a source read from the architected file differs from the reported operand, nothing is written. flush_o then rises with cause_o = 1, which is the source-mismatch code.
- R3: The recomputed result uses these opcodes: 0 add, 1 subtract a-b, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right (shift amount from b[4:0]). A mismatch against the reported result flushes with cause_o = 2. When both checks fail, the cause is 1.
- R4: An instruction accepted at clock edge N that passes both checks shows commit_valid_o with its destination and value during the cycle after edge N+1, and writes the register at the end of that cycle.
- R5: An instruction that reads a register written by the instruction immediately ahead of it sees the new value.
- R6: A failing instruction accepted at edge N raises flush_o for exactly the one cycle after edge N+2. restart_pc_o then holds its program counter. Instructions accepted at edges N+1 and N+2 are discarded without commit.
- R7: in_ready_o is 0 exactly during a flush cycle and 1 otherwise.
- R8: With tmo_limit_i = L > 0, L+1 consecutive cycles without an accepted instruction produce a flush with cause_o = 3. restart_pc_o is then the program counter after the last committed one, or the faulting one after an error. Each acceptance restarts the count, and L = 0 disables the timeout.
- R9: restart_pc_o and cause_o keep their values until the next flush.
- R10: Opcode 7 loads the second operand as an immediate. Its result is that operand, and the second source register is not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tmo_limit_i | input | 16 | idle timeout limit, 0 disables |
| in_valid_i | input | 1 | retiring instruction present |
| in_ready_o | output | 1 | checker accepts an instruction |
| in_op_i | input | 3 | opcode |
| in_rs1_i | input | 5 | first source index |
| in_rs2_i | input | 5 | second source index |
| in_rd_i | input | 5 | destination index |
| in_src1_i | input | 32 | first operand used by primary core |
| in_src2_i | input | 32 | second operand or immediate |
| in_result_i | input | 32 | result produced by primary core |
| in_pc_i | input | 32 | program counter of the instruction |
| commit_valid_o | output | 1 | a checked instruction is committing |
| commit_rd_o | output | 5 | committed destination |
| commit_data_o | output | 32 | committed value |
| flush_o | output | 1 | one-cycle recovery request |
| restart_pc_o | output | 32 | program counter to restart from |
| cause_o | output | 2 | 1 source, 2 result, 3 timeout |

## Verification
The assertions assume that the primary core never presents an instruction during a flush cycle, so every commit can be traced to an acceptance two edges earlier. They also assume that tmo_limit_i changes only while the counter is well below the new limit. The stimulus drives in_valid_i only while in_ready_o is high, and after an error it stays idle through the flush. It changes the limit only right before an acceptance, which restarts the count. All operand values the bench reports come from a bench-side register model. Faults are injected by deliberately corrupting one field.

// File: rtl/chk_pkg.sv
package chk_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SLL = 3'd5,
    OP_SRL = 3'd6,
    OP_IMM = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_SRC  = 2'd1,
    CAUSE_ALU  = 2'd2,
    CAUSE_TMO  = 2'd3
  } cause_e;
endpackage

// File: rtl/chk_alu.sv
module chk_alu
  import chk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shamt;
  assign shamt = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SLL:  res_o = a_i << shamt;
      OP_SRL:  res_o = a_i >> shamt;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/chk_regfile.sv
module chk_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra1_i,
  input  logic [AW-1:0]   ra2_i,
  output logic [XLEN-1:0] rd1_o,
  output logic [XLEN-1:0] rd2_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  // write-to-read bypass for back-to-back dependents
  assign rd1_o = (we_i && wa_i == ra1_i) ? wd_i : mem_q[ra1_i];
  assign rd2_o = (we_i && wa_i == ra2_i) ? wd_i : mem_q[ra2_i];
endmodule

// File: rtl/chk_timeout.sv
module chk_timeout #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= '0;
    else if (accept_i || clear_i) idle_q <= '0;
    else if (idle_q != '1) idle_q <= idle_q + 1'b1;
  end

  assign hit_o = (limit_i != '0) && (idle_q >= limit_i) && !accept_i;
endmodule

// File: rtl/commit_checker.sv
module commit_checker
  import chk_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int TW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TW-1:0]   tmo_limit_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [2:0]      in_op_i,
  input  logic [AW-1:0]   in_rs1_i,
  input  logic [AW-1:0]   in_rs2_i,
  input  logic [AW-1:0]   in_rd_i,
  input  logic [XLEN-1:0] in_src1_i,
  input  logic [XLEN-1:0] in_src2_i,
  input  logic [XLEN-1:0] in_result_i,
  input  logic [XLEN-1:0] in_pc_i,
  output logic            commit_valid_o,
  output logic [AW-1:0]   commit_rd_o,
  output logic [XLEN-1:0] commit_data_o,
  output logic            flush_o,
  output logic [XLEN-1:0] restart_pc_o,
  output logic [1:0]      cause_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic            accept;
  logic            flush_q;
  logic            flush_set;
  logic            tmo_hit;

  // stage 1: captured packet
  logic            s1_valid_q;
  op_e             s1_op_q;
  logic [AW-1:0]   s1_rs1_q, s1_rs2_q, s1_rd_q;
  logic [XLEN-1:0] s1_src1_q, s1_src2_q, s1_res_q, s1_pc_q;

  // stage 2: compare and write
  logic            s2_valid_q;
  logic            s2_src_ok_q;
  logic [AW-1:0]   s2_rd_q;
  logic [XLEN-1:0] s2_calc_q, s2_res_q, s2_pc_q;

  logic [XLEN-1:0] arch1, arch2, alu_b, calc;
  logic            src_ok;
  logic            s2_alu_ok, s2_commit, s2_err;
  logic [XLEN-1:0] next_pc_q;
  logic [XLEN-1:0] restart_pc_q;
  cause_e          cause_q;

  assign in_ready_o = !flush_q;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_op_q    <= OP_ADD;
      s1_rs1_q   <= '0;
      s1_rs2_q   <= '0;
      s1_rd_q    <= '0;
      s1_src1_q  <= '0;
      s1_src2_q  <= '0;
      s1_res_q   <= '0;
      s1_pc_q    <= '0;
    end else begin
      s1_valid_q <= accept && !flush_set;
      if (accept) begin
        s1_op_q   <= op_e'(in_op_i);
        s1_rs1_q  <= in_rs1_i;
        s1_rs2_q  <= in_rs2_i;
        s1_rd_q   <= in_rd_i;
        s1_src1_q <= in_src1_i;
        s1_src2_q <= in_src2_i;
        s1_res_q  <= in_result_i;
        s1_pc_q   <= in_pc_i;
      end
    end
  end

  chk_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (s1_rs1_q),
    .ra2_i (s1_rs2_q),
    .rd1_o (arch1),
    .rd2_o (arch2),
    .we_i  (s2_commit),
    .wa_i  (s2_rd_q),
    .wd_i  (s2_calc_q)
  );

  // immediate form takes the reported second operand as-is
  assign alu_b  = (s1_op_q == OP_IMM) ? s1_src2_q : arch2;
  assign src_ok = (arch1 == s1_src1_q) && ((s1_op_q == OP_IMM) || (arch2 == s1_src2_q));

  chk_alu #(.XLEN(XLEN)) u_alu (
    .op_i (s1_op_q),
    .a_i  (arch1),
    .b_i  (alu_b),
    .res_o(calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid_q  <= 1'b0;
      s2_src_ok_q <= 1'b0;
      s2_rd_q     <= '0;
      s2_calc_q   <= '0;
      s2_res_q    <= '0;
      s2_pc_q     <= '0;
    end else begin
      s2_valid_q <= s1_valid_q && !flush_set;
      if (s1_valid_q) begin
        s2_src_ok_q <= src_ok;
        s2_rd_q     <= s1_rd_q;
        s2_calc_q   <= calc;
        s2_res_q    <= s1_res_q;
        s2_pc_q     <= s1_pc_q;
      end
    end
  end

  assign s2_alu_ok = (s2_calc_q == s2_res_q);
  assign s2_commit = s2_valid_q && s2_src_ok_q && s2_alu_ok;
  assign s2_err    = s2_valid_q && !(s2_src_ok_q && s2_alu_ok);

  chk_timeout #(.CW(TW)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .clear_i (flush_set),
    .limit_i (tmo_limit_i),
    .hit_o   (tmo_hit)
  );

  assign flush_set = s2_err || tmo_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q      <= 1'b0;
      restart_pc_q <= '0;
      cause_q      <= CAUSE_NONE;
      next_pc_q    <= '0;
    end else begin
      flush_q <= flush_set;
      if (s2_commit) next_pc_q <= s2_pc_q + PC_STEP;
      else if (s2_err) next_pc_q <= s2_pc_q;
      if (s2_err) begin
        restart_pc_q <= s2_pc_q;
        cause_q      <= s2_src_ok_q ? CAUSE_ALU : CAUSE_SRC;
      end else if (tmo_hit) begin
        restart_pc_q <= s2_commit ? s2_pc_q + PC_STEP : next_pc_q;
        cause_q      <= CAUSE_TMO;
      end
    end
  end

  assign commit_valid_o = s2_commit;
  assign commit_rd_o    = s2_rd_q;
  assign commit_data_o  = s2_calc_q;
  assign flush_o        = flush_q;
  assign restart_pc_o   = restart_pc_q;
  assign cause_o        = cause_q;
endmodule

// File: rtl/chk_sva.sv
module chk_sva #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            commit_valid_o,
  input logic [AW-1:0]   commit_rd_o,
  input logic            flush_o,
  input logic [XLEN-1:0] restart_pc_o,
  input logic [1:0]      cause_o
);
  a_r6_flush_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

  a_r6_no_commit_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !commit_valid_o);

  a_r4_commit_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> $past(in_valid_i && in_ready_o, 2));

  a_r9_restart_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_o |-> ($stable(restart_pc_o) && $stable(cause_o)));

  a_r2_cause_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> cause_o != 2'd0);

  a_r8_tmo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && cause_o == 2'd3) |-> $past(!(in_valid_i && in_ready_o)));

  a_r4_rd_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> !$isunknown(commit_rd_o));
endmodule

bind commit_checker chk_sva #(.XLEN(XLEN), .NREG(NREG)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .commit_valid_o(commit_valid_o),
  .commit_rd_o   (commit_rd_o),
  .flush_o       (flush_o),
  .restart_pc_o  (restart_pc_o),
  .cause_o       (cause_o)
);

// File: tb/tb_commit_checker.sv
module tb_commit_checker;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_L = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tmo_limit_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [2:0]  in_op_i = '0;
  logic [4:0]  in_rs1_i = '0, in_rs2_i = '0, in_rd_i = '0;
  logic [31:0] in_src1_i = '0, in_src2_i = '0, in_result_i = '0, in_pc_i = '0;
  logic        commit_valid_o;
  logic [4:0]  commit_rd_o;
  logic [31:0] commit_data_o;
  logic        flush_o;
  logic [31:0] restart_pc_o;
  logic [1:0]  cause_o;

  commit_checker dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmo_limit_i(tmo_limit_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_op_i(in_op_i),
    .in_rs1_i(in_rs1_i), .in_rs2_i(in_rs2_i), .in_rd_i(in_rd_i),
    .in_src1_i(in_src1_i), .in_src2_i(in_src2_i), .in_result_i(in_result_i),
    .in_pc_i(in_pc_i), .commit_valid_o(commit_valid_o), .commit_rd_o(commit_rd_o),
    .commit_data_o(commit_data_o), .flush_o(flush_o), .restart_pc_o(restart_pc_o),
    .cause_o(cause_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int flush_cnt = 0;
  int wr_ptr = 0;
  int rd_ptr = 0;
  logic [4:0]  exp_rd  [2048];
  logic [31:0] exp_dat [2048];
  logic [31:0] mdl [32];
  logic [31:0] pc_ctr = 32'h100;
  logic [31:0] last_pc = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[4:0];
      6: return a >> b[4:0];
      default: return b;
    endcase
  endfunction

  // commit and flush monitor, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (flush_o) flush_cnt++;
      if (commit_valid_o) begin
        if (rd_ptr >= wr_ptr) begin
          chk(0, "R4 R6 unexpected commit", {27'd0, commit_rd_o}, 32'hffff_ffff);
        end else begin
          chk(commit_rd_o == exp_rd[rd_ptr], "R4 commit rd", {27'd0, commit_rd_o}, {27'd0, exp_rd[rd_ptr]});
          chk(commit_data_o == exp_dat[rd_ptr], "R3 R5 commit data", commit_data_o, exp_dat[rd_ptr]);
          rd_ptr++;
        end
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drive(input int op, input int rs1, input int rs2, input int rd,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] res, input logic [31:0] pc);
    in_valid_i  = 1'b1;
    in_op_i     = 3'(op);
    in_rs1_i    = 5'(rs1);
    in_rs2_i    = 5'(rs2);
    in_rd_i     = 5'(rd);
    in_src1_i   = a;
    in_src2_i   = b;
    in_result_i = res;
    in_pc_i     = pc;
    step();
    in_valid_i  = 1'b0;
  endtask

  // correct instruction: operands from the model, result expected to commit
  task automatic send_good(input int op, input int rs1, input int rs2, input int rd, input logic [31:0] imm);
    logic [31:0] a, b, r;
    a = mdl[rs1];
    b = (op == 7) ? imm : mdl[rs2];
    r = ref_alu(op, a, b);
    exp_rd[wr_ptr]  = 5'(rd);
    exp_dat[wr_ptr] = r;
    wr_ptr++;
    mdl[rd] = r;
    last_pc = pc_ctr;
    drive(op, rs1, rs2, rd, a, b, r, pc_ctr);
    pc_ctr += 4;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // fault at pc, followed by two younger instructions that must be dropped
  task automatic fault_case(input int op, input bit bad_src, input bit bad_res,
                            input logic [31:0] fpc, input logic [1:0] exp_cause, input string tag);
    logic [31:0] a, b, r;
    int f0;
    f0 = flush_cnt;
    a = mdl[3] ^ (bad_src ? 32'h10 : 32'h0);
    b = mdl[4];
    r = ref_alu(op, mdl[3], mdl[4]) ^ (bad_res ? 32'h1 : 32'h0);
    drive(op, 3, 4, 20, a, b, r, fpc);
    drive(0, 1, 2, 21, mdl[1], mdl[2], mdl[1] + mdl[2], fpc + 4);
    drive(0, 20, 2, 22, mdl[20], mdl[2], mdl[20] + mdl[2], fpc + 8);
    chk(flush_o == 1'b1, {tag, " R6 flush cycle"}, {31'd0, flush_o}, 32'd1);
    chk(in_ready_o == 1'b0, "R7 ready low in flush", {31'd0, in_ready_o}, 32'd0);
    chk(restart_pc_o == fpc, "R6 restart pc", restart_pc_o, fpc);
    chk(cause_o == exp_cause, {tag, " cause"}, {30'd0, cause_o}, {30'd0, exp_cause});
    step();
    chk(flush_o == 1'b0 && in_ready_o == 1'b1, "R6 R7 single flush cycle", {31'd0, flush_o}, 32'd0);
    repeat (3) step();
    chk(restart_pc_o == fpc && cause_o == exp_cause, "R9 restart held", restart_pc_o, fpc);
    chk(flush_cnt == f0 + 1, "R6 one flush", 32'(flush_cnt), 32'(f0 + 1));
    // architected state untouched: reading the rds with model values must commit
    send_good(4, 20, 21, 23, 0);
    send_good(0, 22, 3, 24, 0);
    repeat (3) step();
    chk(flush_cnt == f0 + 1, "R2 R6 state unchanged", 32'(flush_cnt), 32'(f0 + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int f0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk(in_ready_o == 1'b1, "R1 ready", {31'd0, in_ready_o}, 32'd1);
    chk(flush_o == 1'b0 && commit_valid_o == 1'b0, "R1 idle outputs", {31'd0, flush_o}, 32'd0);
    chk(restart_pc_o == 0 && cause_o == 0, "R1 restart/cause", restart_pc_o, 32'd0);
    step();
    send_good(4, 5, 6, 9, 0);          // R1 zero registers pass storage check
    send_good(0, 30, 31, 9, 0);
    repeat (3) step();
    chk(flush_cnt == 0, "R1 registers zero", 32'(flush_cnt), 32'd0);

    // R10 immediates, second source deliberately mismatched
    for (int i = 1; i <= 8; i++)
      send_good(7, 0, 9 + i, i, 32'h9e37_79b9 * i + 32'h8000_0000 * (i % 2) + 32'(i));
    send_good(7, 0, 0, 12, 32'd7);
    send_good(7, 0, 0, 13, 32'd31);
    repeat (3) step();
    chk(flush_cnt == 0, "R10 immediate not compared", 32'(flush_cnt), 32'd0);

    // R3 near-exhaustive sweep of ops over source pairs, back-to-back
    for (int op = 0; op < 7; op++)
      for (int r1 = 1; r1 <= 8; r1++)
        for (int r2 = 1; r2 <= 8; r2++)
          send_good(op, r1, r2, 16 + ((op * 64 + r1 * 8 + r2) % 8), 0);
    // shift amounts at the edges
    send_good(5, 1, 12, 25, 0);
    send_good(6, 1, 13, 26, 0);
    send_good(5, 2, 13, 27, 0);
    repeat (3) step();
    chk(flush_cnt == 0, "R3 sweep no flush", 32'(flush_cnt), 32'd0);

    // R5 dependent chains back-to-back through the bypass
    for (int i = 0; i < 12; i++) send_good(i % 7, 31, (i % 8) + 1, 31, 0);
    for (int i = 0; i < 8; i++) send_good(0, 1, 30, 30, 0);
    for (int i = 0; i < 6; i++) begin
      send_good(4, 28, 2, 29, 0);
      send_good(1, 29, 3, 28, 0);
    end
    repeat (3) step();
    chk(flush_cnt == 0, "R5 bypass chain", 32'(flush_cnt), 32'd0);
    chk(rd_ptr == wr_ptr, "R4 all commits seen", 32'(rd_ptr), 32'(wr_ptr));

    fault_case(0, 1, 0, 32'h4000, 2'd1, "R2 source mismatch");
    fault_case(1, 0, 1, 32'h5000, 2'd2, "R3 result mismatch");
    fault_case(4, 1, 1, 32'h6000, 2'd1, "R3 both mismatch priority");

    // R8 timeout
    pc_ctr = 32'h8000;
    tmo_limit_i = 16'(TMO_L);
    send_good(0, 1, 2, 14, 0);
    repeat (TMO_L) step();
    chk(flush_o == 1'b0, "R8 no early timeout", {31'd0, flush_o}, 32'd0);
    step();
    chk(flush_o == 1'b1, "R8 timeout flush", {31'd0, flush_o}, 32'd1);
    chk(cause_o == 2'd3, "R8 timeout cause", {30'd0, cause_o}, 32'd3);
    chk(restart_pc_o == last_pc + 4, "R8 timeout restart pc", restart_pc_o, last_pc + 4);
    repeat (TMO_L) step();
    chk(flush_o == 1'b0, "R8 gap after flush", {31'd0, flush_o}, 32'd0);
    step();
    chk(flush_o == 1'b1 && restart_pc_o == last_pc + 4, "R8 repeated timeout", {31'd0, flush_o}, 32'd1);
    step();
    // reload on every acceptance
    f0 = flush_cnt;
    for (int i = 0; i < 6; i++) begin
      send_good(3, i + 1, 8, 15, 0);
      repeat (TMO_L - 2) step();
    end
    // disable
    tmo_limit_i = '0;
    send_good(2, 1, 2, 15, 0);
    repeat (4 * TMO_L) step();
    chk(flush_cnt == f0, "R8 reload and disable", 32'(flush_cnt), 32'(f0));
    chk(rd_ptr == wr_ptr, "R4 final commits", 32'(rd_ptr), 32'(wr_ptr));
    finish_up();
  end
endmodule